// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

The block is a down-counter, `CNT_W` bits wide, with an interrupt. It is driven through three memory-mapped registers: a control/status word, a modulus word and a read-only live count. A power-of-two prescaler divides the clock and produces a count tick. On every tick the counter moves one step down. In reload mode it starts again from the modulus. In free-running mode it starts again from all ones.

When the counter is at zero on a tick, an interrupt flag is set. While the interrupt enable is also set, the flag drives a level interrupt line. Software clears the flag by writing a one to it. Software can also change the modulus so that the counter is loaded at once, or so that the new value is used only at the next wrap.

The register port has no handshake, because the block never stalls. A write is taken on the clock edge at which `reg_wr` is high. `reg_rdata` is a combinational function of `reg_addr` and the register state.

Top module: `periodic_irq_timer`

## Requirements
- R1: After reset the control word reads 0x0000, the modulus reads 0x0000, the count reads 0xFFFF, and `irq` is low.
- R2: Byte offset 0 holds the control word, offset 2 the modulus and offset 4 the count. The control word stores only these fields: bit 0 enable, bit 1 reload mode, bit 3 interrupt enable, bit 4 overwrite, bits 5 and 6 as spare configuration, and bits 11:8 as the prescaler code. Every other bit reads 0, except bit 2, which is the flag. A write to offset 4 or to any offset other than 0 and 2 changes nothing, and those other offsets read 0.
- R3: `irq` is high exactly when the flag (bit 2) and the interrupt enable (bit 3) are both set.
- R4: Writing 1 to bit 2 of the control word clears the flag. Writing 0 to it leaves the flag as it was. No write can set the flag.
- R5: A control write that differs from the stored word only in bit 3 (bit 2 excluded) does not disturb the counter or the prescaler.
- R6: Any other control write restarts the prescaler and loads the counter. The value loaded is the modulus if the new bit 1 is set, and 0xFFFF if it is clear. The counter then counts only while bit 0 is set; with bit 0 clear it holds its value.
- R7: With prescaler code c, ticks come every 2^(c+1) cycles. The first tick after a restart comes 2^(c+1) cycles after the restarting write.
- R8: A tick with the count at zero sets the flag and reloads the counter: from the modulus in reload mode, from 0xFFFF otherwise. Any other tick decrements the count by one.
- R9: Any write to the modulus clears the flag.
- R10: With overwrite (bit 4) set, a modulus write loads the counter at once with the written value, in either mode. With overwrite clear, the count is untouched. In that case reload mode picks up the new value at the next wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, taken on the rising edge |
| reg_addr | input | 3 | Byte offset of the register |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
A write takes effect on the edge that captures it. The new register value, the count load and the flag clear can all be read back before the next edge. After a restart with code c and modulus M, the first decrement lands 2^(c+1) edges after the write. The flag and the reload land (M+1)*2^(c+1) edges after it. The bench counts falling edges from the end of each write task and samples at those exact edges. It also samples one edge earlier, to prove nothing fires early.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int BIT_EN   = 0;
  localparam int BIT_RLD  = 1;
  localparam int BIT_FLAG = 2;
  localparam int BIT_IE   = 3;
  localparam int BIT_OVW  = 4;
  localparam int PRE_LSB  = 8;

  typedef enum logic [2:0] {
    OFS_CTRL = 3'd0,
    OFS_MOD  = 3'd2,
    OFS_CNT  = 3'd4
  } reg_ofs_e;
endpackage

// File: rtl/tmr_ctrl_regs.sv
`timescale 1ns/1ps
module tmr_ctrl_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             wrap,
  output logic             run_en,
  output logic [PRE_W-1:0] pre_code,
  output logic             restart,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] ctrl_word,
  output logic [CNT_W-1:0] modulus,
  output logic             irq
);
  localparam logic [CNT_W-1:0] PRE_FIELD    = CNT_W'(((1 << PRE_W) - 1) << PRE_LSB);
  localparam logic [CNT_W-1:0] KEEP_MASK    = PRE_FIELD | CNT_W'(7'h7B);
  localparam logic [CNT_W-1:0] RESTART_MASK = KEEP_MASK & ~(CNT_W'(1) << BIT_IE);
  localparam logic [CNT_W-1:0] ALL_ONES     = '1;

  logic [CNT_W-1:0] ctrl_q;
  logic [CNT_W-1:0] mod_q;
  logic             flag_q;
  logic             wr_ctrl, wr_mod, ovw_load;

  assign wr_ctrl  = wr && (addr == OFS_CTRL);
  assign wr_mod   = wr && (addr == OFS_MOD);
  assign restart  = wr_ctrl && (((wdata ^ ctrl_q) & RESTART_MASK) != '0);
  assign ovw_load = wr_mod && ctrl_q[BIT_OVW];
  assign load     = restart || ovw_load;

  always_comb begin
    if (ovw_load)
      load_val = wdata;
    else if (wdata[BIT_RLD])
      load_val = mod_q;
    else
      load_val = ALL_ONES;
  end

  assign reload_val = ctrl_q[BIT_RLD] ? mod_q : ALL_ONES;
  assign run_en     = ctrl_q[BIT_EN];
  assign pre_code   = ctrl_q[PRE_LSB +: PRE_W];
  assign ctrl_word  = ctrl_q | (CNT_W'(flag_q) << BIT_FLAG);
  assign modulus    = mod_q;
  assign irq        = flag_q & ctrl_q[BIT_IE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mod_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata & KEEP_MASK;
      if (wr_mod)  mod_q  <= wdata;
      if (wrap)
        flag_q <= 1'b1;
      else if (wr_mod || (wr_ctrl && wdata[BIT_FLAG]))
        flag_q <= 1'b0;
    end
  end

  assert_flag_rise_needs_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(wrap));
  assert_mod_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mod && !wrap) |=> !flag_q);
  assert_zero_write_keeps_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !wr_mod && !(wr_ctrl && wdata[BIT_FLAG])) |=> flag_q);
endmodule

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [PRE_W-1:0] code,
  output logic             tick
);
  localparam int DIV_W = 1 << PRE_W;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < DIV_W; i++)
      mask[i] = (PRE_W'(i) <= code);
  end

  assign tick = en && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)
      div_q <= '0;
    else if (clr)
      div_q <= '0;
    else if (en)
      div_q <= div_q + 1'b1;
  end

  assert_clear_delays_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !tick);
endmodule

// File: rtl/tmr_downcount.sv
`timescale 1ns/1ps
module tmr_downcount #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap = tick && (cnt_q == '0);
  assign cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '1;
    else if (load)
      cnt_q <= load_val;
    else if (wrap)
      cnt_q <= reload_val;
    else if (tick)
      cnt_q <= cnt_q - 1'b1;
  end

  assert_hold_without_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));
  assert_step_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/periodic_irq_timer.sv
`timescale 1ns/1ps
module periodic_irq_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq
);
  logic             run_en, restart, load, wrap, tick;
  logic [PRE_W-1:0] pre_code;
  logic [CNT_W-1:0] load_val, reload_val, ctrl_word, modulus, cnt;

  tmr_ctrl_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .wrap(wrap), .run_en(run_en), .pre_code(pre_code), .restart(restart),
    .load(load), .load_val(load_val), .reload_val(reload_val),
    .ctrl_word(ctrl_word), .modulus(modulus), .irq(irq)
  );

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(run_en), .clr(restart),
    .code(pre_code), .tick(tick)
  );

  tmr_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
    .load_val(load_val), .reload_val(reload_val), .cnt(cnt), .wrap(wrap)
  );

  always_comb begin
    case (reg_addr)
      OFS_CTRL: reg_rdata = ctrl_word;
      OFS_MOD:  reg_rdata = modulus;
      OFS_CNT:  reg_rdata = cnt;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: tb/periodic_irq_timer_test.sv
`timescale 1ns/1ps
module periodic_irq_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;

  periodic_irq_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    chk_reg("R1 ctrl", 3'd0, 16'h0000);
    chk_reg("R1 mod", 3'd2, 16'h0000);
    chk_reg("R1 cnt", 3'd4, 16'hFFFF);
    chk("R1 irq", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_decode;
    wr(3'd2, 16'h1234);
    chk_reg("R2 mod readback", 3'd2, 16'h1234);
    wr(3'd0, 16'hF0F0);
    chk_reg("R2 ctrl stored fields", 3'd0, 16'h0070);
    wr(3'd4, 16'h0000);
    chk_reg("R2 count write ignored", 3'd4, 16'hFFFF);
    wr(3'd6, 16'hFFFF);
    chk_reg("R2 undefined offset reads zero", 3'd6, 16'h0000);
    chk_reg("R2 undefined write leaves ctrl", 3'd0, 16'h0070);
    chk_reg("R2 undefined write leaves mod", 3'd2, 16'h1234);
    wr(3'd0, 16'h0000);
    waitn(3);
    chk_reg("R6 disabled counter holds", 3'd4, 16'hFFFF);
  endtask

  // reload mode, code 0: tick every 2 edges, modulus 3 -> wrap after 8 edges
  task automatic t_reload_irq;
    wr(3'd2, 16'h0003);
    wr(3'd0, 16'h0003);
    chk_reg("R6 restart loads modulus", 3'd4, 16'h0003);
    waitn(2);
    chk_reg("R7 first decrement", 3'd4, 16'h0002);
    waitn(5);
    chk_reg("R8 no early flag", 3'd0, 16'h0003);
    chk_reg("R8 count at zero", 3'd4, 16'h0000);
    waitn(1);
    chk_reg("R8 flag on wrap", 3'd0, 16'h0007);
    chk_reg("R8 reload on wrap", 3'd4, 16'h0003);
    chk("R3 irq masked", {15'd0, irq}, 16'h0);
    // enable-only write: no restart
    wr(3'd0, 16'h000B);
    chk("R3 irq raised", {15'd0, irq}, 16'h1);
    chk_reg("R5 count kept", 3'd4, 16'h0003);
    waitn(1);
    chk_reg("R5 prescaler kept", 3'd4, 16'h0002);
    wr(3'd0, 16'h000B);
    chk_reg("R4 zero write keeps flag", 3'd0, 16'h000F);
    chk("R4 irq still high", {15'd0, irq}, 16'h1);
    wr(3'd0, 16'h000F);
    chk_reg("R4 one write clears flag", 3'd0, 16'h000B);
    chk("R3 irq low after clear", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_free_overwrite;
    wr(3'd0, 16'h0011);
    chk_reg("R6 free mode loads all ones", 3'd4, 16'hFFFF);
    wr(3'd2, 16'h0002);
    chk_reg("R10 overwrite loads count", 3'd4, 16'h0002);
    waitn(4);
    chk_reg("R8 free count at zero", 3'd4, 16'h0000);
    waitn(1);
    chk_reg("R8 free wrap to all ones", 3'd4, 16'hFFFF);
    chk_reg("R8 free wrap flag", 3'd0, 16'h0015);
  endtask

  task automatic t_reload_no_overwrite;
    wr(3'd0, 16'h0003);
    chk_reg("R6 restart loads modulus 2", 3'd4, 16'h0002);
    wr(3'd2, 16'h0005);
    chk_reg("R9 modulus write clears flag", 3'd0, 16'h0003);
    chk_reg("R10 no overwrite keeps count", 3'd4, 16'h0002);
    waitn(5);
    chk_reg("R10 new modulus at wrap", 3'd4, 16'h0005);
    chk_reg("R8 flag after wrap", 3'd0, 16'h0007);
  endtask

  task automatic t_reload_overwrite;
    wr(3'd0, 16'h0013);
    chk_reg("R6 restart loads modulus 5", 3'd4, 16'h0005);
    wr(3'd2, 16'h0001);
    chk_reg("R10 reload overwrite loads count", 3'd4, 16'h0001);
    waitn(1);
    chk_reg("R8 decrement to zero", 3'd4, 16'h0000);
    waitn(2);
    chk_reg("R8 wrap reload 1", 3'd4, 16'h0001);
    chk_reg("R8 flag set", 3'd0, 16'h0017);
    wr(3'd2, 16'h0001);
    chk_reg("R9 modulus write clears set flag", 3'd0, 16'h0013);
  endtask

  task automatic t_prescale;
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'h0000);
    wr(3'd0, 16'h0303);
    chk_reg("R6 restart loads zero", 3'd4, 16'h0000);
    waitn(15);
    chk_reg("R7 no tick before 16", 3'd0, 16'h0303);
    waitn(1);
    chk_reg("R7 tick at 16", 3'd0, 16'h0307);
    chk_reg("R8 reload zero", 3'd4, 16'h0000);
  endtask

  initial begin
    #(200000 * 20);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    waitn(3);
    rst_n = 1'b1;
    waitn(1);
    t_reset();
    t_decode();
    t_reload_irq();
    t_free_overwrite();
    t_reload_no_overwrite();
    t_reload_overwrite();
    t_prescale();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule